// File: doc/BRIEF.md
# Network Interrupt Moderation Controller

This block gathers interrupt causes from a network interface and decides when the host interrupt line goes high. Cause pulses accumulate in a cause register. A mask register selects which causes may raise the line. A throttle interval can hold back non-urgent causes so that several of them share one interrupt. Receive and transmit completions can also be held back by per-direction delay timers. Each direction has a packet timer, which restarts on every completion, and an absolute timer, which bounds the total wait.

When the line is raised, all pending timers are dropped and their cause bits are merged into the vector. The host therefore sees one interrupt that reports everything outstanding. Reading the vector through a read-clear strobe empties it and lowers the line. Time is counted in ticks. A tick is produced every `TICK_CYCLES` clocks, and one throttle interval unit lasts `THR_SCALE` ticks.

Top module: `irq_moderator`

## Requirements
- R1: A non-immediate cause pulse (`causeNow`=0) that shares any bit with the causes already held is discarded. It sets no bit and does not start or restart the throttle timer.
- R2: An accepted cause raises the interrupt at the next edge when the throttle interval is zero or `causeNow` is 1, and cancels a pending throttle timer. Otherwise it starts a throttle timer of interval×`THR_SCALE` ticks, but only if none is running. When that timer expires, a post attempt is made.
- R3: A post attempt raises the interrupt only if (cause AND mask) over bits 6..0 is nonzero. While the line is high, that AND is never zero.
- R4: A post cancels every running delay timer. If a receive timer was running, it sets cause bit 1 (receive timer). If a transmit timer was running, it sets cause bit 0 (transmit done).
- R5: A post sets cause bit 7, and `irqOut` always equals cause bit 7. After reset the cause vector is 0 and `irqOut` is 0.
- R6: A mask write (`wrSel`=0, `wrData` bits 6..0) that leaves (cause AND mask) zero cancels the throttle timer and lowers the line, keeping bits 6..0. If the AND is nonzero, the block posts at the next edge when the interval is zero, or else starts the throttle timer if it is idle.
- R7: Each receive completion restarts the receive packet timer (`wrSel`=2) when that value is nonzero. It starts the receive absolute timer (`wrSel`=3) only when that timer is idle and both values are nonzero. When either timer expires, bit 1 is posted immediately.
- R8: With a receive packet delay of zero, each receive completion posts bit 1 as a non-immediate cause.
- R9: A receive completion with `rxLen` ≤ the small-packet threshold (`wrSel`=6) posts bit 2 as a non-immediate cause.
- R10: `rdClr` clears the cause vector to zero and lowers `irqOut` at the next edge. Causes arriving in the same cycle still land.
- R11: The transmit side mirrors receive, using packet delay (`wrSel`=4), absolute delay (`wrSel`=5) and cause bit 0. The throttle interval is written with `wrSel`=1. All five timers run, cancel and reload independently, and none is ever running with a zero count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| causeIn | input | 7 | Cause pulses, one bit per cause |
| causeNow | input | 1 | Marks this cycle's causes as immediate |
| rxDone | input | 1 | Receive completion event |
| rxLen | input | LEN_W | Length of the completed receive packet |
| txDone | input | 1 | Transmit completion event |
| wrEn | input | 1 | Configuration write strobe |
| wrSel | input | 3 | Configuration register select |
| wrData | input | DLY_W | Configuration write data |
| rdClr | input | 1 | Read-and-clear strobe for the cause vector |
| irqOut | output | 1 | Level interrupt to the host |
| causeOut | output | 8 | Cause vector, bit 7 is the asserted flag |

## Verification
The throttle and delay paths are swept across every small interval and delay value. The interrupt is checked one cycle before and at the expected edge, which catches off-by-one errors in timer length. Staggered completions separate packet-timer restart from absolute-timer bounding. A second identical pulse during a throttle window shows whether duplicates wrongly restart the timer. Stale timers are uncovered by clearing after a post and then watching for a late, unwanted interrupt. Simultaneous receive and transmit completions show whether a post from one direction merges the other direction's pending cause.

// File: rtl/irq_mod_pkg.sv
package irq_mod_pkg;
  localparam int SRC_W      = 7;
  localparam int CAUSE_W    = 8;
  localparam int BIT_TXDW   = 0;
  localparam int BIT_RXT    = 1;
  localparam int BIT_SRPD   = 2;
  localparam int BIT_ASSERT = 7;

  localparam int NUM_TMR = 5;
  localparam int T_THR   = 0;
  localparam int T_RXP   = 1;
  localparam int T_RXA   = 2;
  localparam int T_TXP   = 3;
  localparam int T_TXA   = 4;

  typedef enum logic [2:0] {
    SEL_MASK     = 3'd0,
    SEL_THROTTLE = 3'd1,
    SEL_RXPKT    = 3'd2,
    SEL_RXABS    = 3'd3,
    SEL_TXPKT    = 3'd4,
    SEL_TXABS    = 3'd5,
    SEL_SMALL    = 3'd6
  } reg_sel_e;

  typedef struct packed {
    logic [SRC_W-1:0]   setBits;
    logic               assertSet;
    logic               assertClr;
    logic [NUM_TMR-1:0] load;
    logic [NUM_TMR-1:0] cancel;
  } ctrl_strobe_t;
endpackage

// File: rtl/irq_mod_timer.sv
module irq_mod_timer #(
  parameter int CNT_W = 18
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             load,
  input  logic             cancel,
  input  logic [CNT_W-1:0] loadVal,
  output logic             active,
  output logic             expire
);
  logic [CNT_W-1:0] cnt;
  logic             running;

  assign expire = running && tick && (cnt == CNT_W'(1));
  assign active = running;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (cancel) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (load) begin
      running <= 1'b1;
      cnt     <= loadVal;
    end else if (expire) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (running && tick) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  // R11: a running timer always holds a live count
  assert_live_count_R11: assert property (@(posedge clk) disable iff (!rstN)
    running |-> (cnt != '0));

  // R11: the control never arms a timer with a zero length
  assert_no_zero_load_R11: assert property (@(posedge clk) disable iff (!rstN)
    (load && !cancel) |-> (loadVal != '0));
endmodule

// File: rtl/irq_mod_ctrl.sv
module irq_mod_ctrl
  import irq_mod_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int DLY_W = 16
) (
  input  logic [SRC_W-1:0]   causeIn,
  input  logic               causeNow,
  input  logic               rxDone,
  input  logic [LEN_W-1:0]   rxLen,
  input  logic               txDone,
  input  logic               wrEn,
  input  logic [2:0]         wrSel,
  input  logic               rdClr,
  input  logic [CAUSE_W-1:0] cause,
  input  logic [SRC_W-1:0]   maskNext,
  input  logic [NUM_TMR-1:0] cfgZero,
  input  logic [LEN_W-1:0]   smallThr,
  input  logic [NUM_TMR-1:0] tmrActive,
  input  logic [NUM_TMR-1:0] tmrExpire,
  output ctrl_strobe_t       strobe
);
  localparam int CMP_W = (LEN_W > DLY_W) ? LEN_W : DLY_W;

  logic [SRC_W-1:0] srcCause, baseCause, setPre, pending, foldBits;
  logic maskWr, extAcc, extImm, extSlow;
  logic rxDirAcc, smallAcc, txDirAcc, slowAcc;
  logic rxFire, txFire, thrFire;
  logic ldRxP, ldRxA, ldTxP, ldTxA;
  logic maskedNz, maskOn, maskDrop, immPost, thrStart, doPost;
  logic rxRunNext, txRunNext, isSmall;

  assign srcCause  = cause[SRC_W-1:0];
  assign baseCause = rdClr ? '0 : srcCause;
  assign maskWr    = wrEn && (reg_sel_e'(wrSel) == SEL_MASK);

  // external causes: overlap with held bits drops the whole pulse unless urgent
  assign extAcc  = (|causeIn) && (causeNow || !(|(causeIn & srcCause)));
  assign extImm  = extAcc && causeNow;
  assign extSlow = extAcc && !causeNow;

  assign isSmall  = CMP_W'(rxLen) <= CMP_W'(smallThr);
  assign rxDirAcc = rxDone && cfgZero[T_RXP] && !srcCause[BIT_RXT];
  assign smallAcc = rxDone && isSmall && !srcCause[BIT_SRPD];
  assign txDirAcc = txDone && cfgZero[T_TXP] && !srcCause[BIT_TXDW];
  assign slowAcc  = extSlow || rxDirAcc || smallAcc || txDirAcc;

  assign rxFire  = tmrExpire[T_RXP] || tmrExpire[T_RXA];
  assign txFire  = tmrExpire[T_TXP] || tmrExpire[T_TXA];
  assign thrFire = tmrExpire[T_THR];

  // delay timer arming
  assign ldRxP = rxDone && !cfgZero[T_RXP];
  assign ldRxA = ldRxP && !cfgZero[T_RXA] && !tmrActive[T_RXA];
  assign ldTxP = txDone && !cfgZero[T_TXP];
  assign ldTxA = ldTxP && !cfgZero[T_TXA] && !tmrActive[T_TXA];

  always_comb begin
    setPre = extAcc ? causeIn : '0;
    if (rxDirAcc || rxFire) setPre[BIT_RXT]  = 1'b1;
    if (smallAcc)           setPre[BIT_SRPD] = 1'b1;
    if (txDirAcc || txFire) setPre[BIT_TXDW] = 1'b1;
  end

  assign pending  = baseCause | setPre;
  assign maskedNz = |(pending & maskNext);
  assign maskOn   = maskWr && maskedNz;
  assign maskDrop = maskWr && !maskedNz;

  assign immPost  = extImm || rxFire || txFire || thrFire ||
                    ((slowAcc || maskOn) && cfgZero[T_THR]);
  assign thrStart = !immPost && !tmrActive[T_THR] &&
                    (slowAcc || maskOn) && !cfgZero[T_THR];
  assign doPost   = immPost && maskedNz;

  // timers that would still be pending after this edge, before a post cancels them
  assign rxRunNext = (tmrActive[T_RXP] && !tmrExpire[T_RXP]) || ldRxP ||
                     (tmrActive[T_RXA] && !tmrExpire[T_RXA]) || ldRxA;
  assign txRunNext = (tmrActive[T_TXP] && !tmrExpire[T_TXP]) || ldTxP ||
                     (tmrActive[T_TXA] && !tmrExpire[T_TXA]) || ldTxA;

  always_comb begin
    foldBits = '0;
    foldBits[BIT_RXT]  = rxRunNext;
    foldBits[BIT_TXDW] = txRunNext;
  end

  always_comb begin
    strobe           = '0;
    strobe.setBits   = setPre | (doPost ? foldBits : '0);
    strobe.assertSet = doPost;
    strobe.assertClr = maskDrop;
    strobe.load[T_THR] = thrStart;
    strobe.load[T_RXP] = ldRxP;
    strobe.load[T_RXA] = ldRxA;
    strobe.load[T_TXP] = ldTxP;
    strobe.load[T_TXA] = ldTxA;
    strobe.cancel[T_THR] = immPost || maskDrop;
    strobe.cancel[T_RXP] = doPost;
    strobe.cancel[T_RXA] = doPost;
    strobe.cancel[T_TXP] = doPost;
    strobe.cancel[T_TXA] = doPost;
  end
endmodule

// File: rtl/irq_mod_datapath.sv
module irq_mod_datapath
  import irq_mod_pkg::*;
#(
  parameter int DLY_W       = 16,
  parameter int LEN_W       = 16,
  parameter int THR_SCALE   = 64,
  parameter int TICK_CYCLES = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [2:0]         wrSel,
  input  logic [DLY_W-1:0]   wrData,
  input  logic               rdClr,
  input  ctrl_strobe_t       strobe,
  output logic [CAUSE_W-1:0] cause,
  output logic [SRC_W-1:0]   maskNext,
  output logic [NUM_TMR-1:0] cfgZero,
  output logic [LEN_W-1:0]   smallThr,
  output logic [NUM_TMR-1:0] tmrActive,
  output logic [NUM_TMR-1:0] tmrExpire
);
  localparam int CNT_W  = DLY_W + $clog2(THR_SCALE) + 1;
  localparam int PRE_W  = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;

  logic [SRC_W-1:0]   maskReg;
  logic [DLY_W-1:0]   dlyReg [NUM_TMR];
  logic [LEN_W-1:0]   smallReg;
  logic [CAUSE_W-1:0] causeReg;
  logic [CNT_W-1:0]   loadVal [NUM_TMR];
  logic               tick;
  reg_sel_e           sel;

  assign sel = reg_sel_e'(wrSel);

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskReg  <= '0;
      smallReg <= '0;
      for (int i = 0; i < NUM_TMR; i++) dlyReg[i] <= '0;
    end else if (wrEn) begin
      case (sel)
        SEL_MASK:     maskReg       <= wrData[SRC_W-1:0];
        SEL_THROTTLE: dlyReg[T_THR] <= wrData;
        SEL_RXPKT:    dlyReg[T_RXP] <= wrData;
        SEL_RXABS:    dlyReg[T_RXA] <= wrData;
        SEL_TXPKT:    dlyReg[T_TXP] <= wrData;
        SEL_TXABS:    dlyReg[T_TXA] <= wrData;
        SEL_SMALL:    smallReg      <= LEN_W'(wrData);
        default: ;
      endcase
    end
  end

  assign maskNext = (wrEn && sel == SEL_MASK) ? wrData[SRC_W-1:0] : maskReg;
  assign smallThr = smallReg;

  // cause vector
  always_ff @(posedge clk) begin
    if (!rstN) begin
      causeReg <= '0;
    end else begin
      causeReg[SRC_W-1:0] <= (rdClr ? '0 : causeReg[SRC_W-1:0]) | strobe.setBits;
      if (strobe.assertSet)                 causeReg[BIT_ASSERT] <= 1'b1;
      else if (rdClr || strobe.assertClr)   causeReg[BIT_ASSERT] <= 1'b0;
    end
  end
  assign cause = causeReg;

  // tick prescaler
  generate
    if (TICK_CYCLES > 1) begin : g_pre
      logic [PRE_W-1:0] preCnt;
      always_ff @(posedge clk) begin
        if (!rstN || preCnt == PRE_W'(TICK_CYCLES - 1)) preCnt <= '0;
        else                                           preCnt <= preCnt + PRE_W'(1);
      end
      assign tick = (preCnt == PRE_W'(TICK_CYCLES - 1));
    end else begin : g_nopre
      assign tick = 1'b1;
    end
  endgenerate

  // timer lengths: throttle counts in units of THR_SCALE ticks
  assign loadVal[T_THR] = CNT_W'(dlyReg[T_THR]) * CNT_W'(THR_SCALE);
  generate
    for (genvar d = 1; d < NUM_TMR; d++) begin : g_len
      assign loadVal[d] = CNT_W'(dlyReg[d]);
    end
    for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
      assign cfgZero[t] = (dlyReg[t] == '0);
      irq_mod_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk     (clk),
        .rstN    (rstN),
        .tick    (tick),
        .load    (strobe.load[t]),
        .cancel  (strobe.cancel[t]),
        .loadVal (loadVal[t]),
        .active  (tmrActive[t]),
        .expire  (tmrExpire[t])
      );
    end
  endgenerate

  // R3: the line is only high while an enabled cause is held
  assert_masked_live_R3: assert property (@(posedge clk) disable iff (!rstN)
    causeReg[BIT_ASSERT] |-> (|(causeReg[SRC_W-1:0] & maskReg)));

  // R2: a fresh assertion leaves no throttle timer pending
  assert_post_stops_throttle_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(causeReg[BIT_ASSERT]) |-> !tmrActive[T_THR]);

  // R4: after a post no delay timer is left running
  assert_post_stops_delays_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.assertSet |=> (tmrActive[NUM_TMR-1:1] == '0));

  // R6: writing an all-zero mask drops the line
  assert_zero_mask_drops_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && sel == SEL_MASK && wrData[SRC_W-1:0] == '0) |=> !causeReg[BIT_ASSERT]);

  // R10: a read-clear with nothing arriving empties the vector
  assert_read_clears_R10: assert property (@(posedge clk) disable iff (!rstN)
    (rdClr && strobe.setBits == '0 && !strobe.assertSet) |=> (causeReg == '0));
endmodule

// File: rtl/irq_moderator.sv
module irq_moderator
  import irq_mod_pkg::*;
#(
  parameter int DLY_W       = 16,
  parameter int LEN_W       = 16,
  parameter int THR_SCALE   = 64,
  parameter int TICK_CYCLES = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [SRC_W-1:0]   causeIn,
  input  logic               causeNow,
  input  logic               rxDone,
  input  logic [LEN_W-1:0]   rxLen,
  input  logic               txDone,
  input  logic               wrEn,
  input  logic [2:0]         wrSel,
  input  logic [DLY_W-1:0]   wrData,
  input  logic               rdClr,
  output logic               irqOut,
  output logic [CAUSE_W-1:0] causeOut
);
  ctrl_strobe_t       strobe;
  logic [CAUSE_W-1:0] cause;
  logic [SRC_W-1:0]   maskNext;
  logic [NUM_TMR-1:0] cfgZero, tmrActive, tmrExpire;
  logic [LEN_W-1:0]   smallThr;

  irq_mod_ctrl #(.LEN_W(LEN_W), .DLY_W(DLY_W)) u_ctrl (
    .causeIn   (causeIn),
    .causeNow  (causeNow),
    .rxDone    (rxDone),
    .rxLen     (rxLen),
    .txDone    (txDone),
    .wrEn      (wrEn),
    .wrSel     (wrSel),
    .rdClr     (rdClr),
    .cause     (cause),
    .maskNext  (maskNext),
    .cfgZero   (cfgZero),
    .smallThr  (smallThr),
    .tmrActive (tmrActive),
    .tmrExpire (tmrExpire),
    .strobe    (strobe)
  );

  irq_mod_datapath #(
    .DLY_W(DLY_W), .LEN_W(LEN_W), .THR_SCALE(THR_SCALE), .TICK_CYCLES(TICK_CYCLES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrSel     (wrSel),
    .wrData    (wrData),
    .rdClr     (rdClr),
    .strobe    (strobe),
    .cause     (cause),
    .maskNext  (maskNext),
    .cfgZero   (cfgZero),
    .smallThr  (smallThr),
    .tmrActive (tmrActive),
    .tmrExpire (tmrExpire)
  );

  assign causeOut = cause;
  assign irqOut   = cause[BIT_ASSERT];

  // R1: a lone repeated slow cause leaves the vector untouched
  assert_dup_ignored_R1: assert property (@(posedge clk) disable iff (!rstN)
    ((|(causeIn & cause[SRC_W-1:0])) && !causeNow && !rxDone && !txDone &&
     !wrEn && !rdClr && tmrExpire == '0) |=> $stable(causeOut));
endmodule

// File: tb/irq_moderator_tb_top.sv
module irq_moderator_tb_top;
  localparam int DLY_W = 8;
  localparam int LEN_W = 11;
  localparam int SCALE = 2;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [6:0]       causeIn = '0;
  logic             causeNow = 1'b0;
  logic             rxDone = 1'b0;
  logic [LEN_W-1:0] rxLen = '0;
  logic             txDone = 1'b0;
  logic             wrEn = 1'b0;
  logic [2:0]       wrSel = '0;
  logic [DLY_W-1:0] wrData = '0;
  logic             rdClr = 1'b0;
  logic             irqOut;
  logic [7:0]       causeOut;

  int nChecks = 0;
  int nFail   = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  irq_moderator #(
    .DLY_W(DLY_W), .LEN_W(LEN_W), .THR_SCALE(SCALE), .TICK_CYCLES(1)
  ) dut_i (
    .clk(clk), .rstN(rstN), .causeIn(causeIn), .causeNow(causeNow),
    .rxDone(rxDone), .rxLen(rxLen), .txDone(txDone), .wrEn(wrEn),
    .wrSel(wrSel), .wrData(wrData), .rdClr(rdClr),
    .irqOut(irqOut), .causeOut(causeOut)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 50000 && !done) begin
      done = 1'b1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual %0d cycles expected under 50000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    nChecks++;
    if (act !== expv) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  task automatic nxt();
    @(negedge clk);
  endtask

  task automatic waitN(input int n);
    for (int i = 0; i < n; i++) nxt();
  endtask

  task automatic wrReg(input logic [2:0] sel, input logic [DLY_W-1:0] val);
    wrEn = 1'b1; wrSel = sel; wrData = val;
    nxt();
    wrEn = 1'b0;
  endtask

  task automatic pulse(input logic [6:0] bits, input logic now);
    causeIn = bits; causeNow = now;
    nxt();
    causeIn = '0; causeNow = 1'b0;
  endtask

  task automatic rx(input int len);
    rxDone = 1'b1; rxLen = LEN_W'(len);
    nxt();
    rxDone = 1'b0;
  endtask

  task automatic tx();
    txDone = 1'b1;
    nxt();
    txDone = 1'b0;
  endtask

  task automatic clr();
    rdClr = 1'b1;
    nxt();
    rdClr = 1'b0;
  endtask

  task automatic cfg(input int iv, input int rxp, input int rxa,
                     input int txp, input int txa, input int sm);
    wrReg(3'd1, DLY_W'(iv));
    wrReg(3'd2, DLY_W'(rxp));
    wrReg(3'd3, DLY_W'(rxa));
    wrReg(3'd4, DLY_W'(txp));
    wrReg(3'd5, DLY_W'(txa));
    wrReg(3'd6, DLY_W'(sm));
  endtask

  initial begin
    waitN(3);
    rstN = 1'b1;
    nxt();
    check("R5 reset irq", 32'(irqOut), 0);
    check("R5 reset cause", 32'(causeOut), 0);

    // immediate post with zero interval
    wrReg(3'd0, 8'h7F);
    cfg(0, 0, 0, 0, 0, 0);
    pulse(7'h08, 1'b0);
    check("R2 zero interval posts", 32'(causeOut), 32'h88);
    check("R5 irq follows bit7", 32'(irqOut), 1);
    clr();
    check("R10 read clears vector", 32'(causeOut), 0);
    check("R10 read lowers irq", 32'(irqOut), 0);

    // masking
    wrReg(3'd0, 8'h00);
    pulse(7'h10, 1'b0);
    check("R3 masked cause held", 32'(causeOut), 32'h10);
    check("R3 masked no irq", 32'(irqOut), 0);
    wrReg(3'd0, 8'h10);
    check("R6 unmask posts", 32'(causeOut), 32'h90);
    wrReg(3'd0, 8'h01);
    check("R6 remask drops irq", 32'(irqOut), 0);
    check("R6 remask keeps bits", 32'(causeOut), 32'h10);
    wrReg(3'd0, 8'h7F);
    check("R6 mask reopen posts", 32'(causeOut), 32'h90);
    clr();

    // throttle with duplicate and extra cause
    wrReg(3'd1, 8'd5);
    pulse(7'h08, 1'b0);              // P0, throttle ends at P10
    waitN(2);
    pulse(7'h08, 1'b0);              // P3 duplicate
    check("R1 duplicate leaves cause", 32'(causeOut), 32'h08);
    waitN(2);
    pulse(7'h20, 1'b0);              // P6 new bit, no restart
    check("R2 throttle holds irq", 32'(causeOut), 32'h28);
    waitN(3);
    check("R1 no early irq", 32'(irqOut), 0);
    nxt();
    check("R1 throttle not restarted", 32'(causeOut), 32'hA8);
    clr();

    // immediate cancels throttle
    pulse(7'h08, 1'b0);              // P0
    nxt();
    pulse(7'h40, 1'b1);              // P2
    check("R2 immediate posts", 32'(causeOut), 32'hC8);
    clr();                           // P3
    pulse(7'h08, 1'b0);              // P4, new throttle to P14
    waitN(9);
    check("R2 old throttle cancelled", 32'(irqOut), 0);
    nxt();
    check("R2 new throttle fires", 32'(irqOut), 1);
    clr();

    // throttle sweep
    for (int iv = 1; iv <= 4; iv++) begin
      wrReg(3'd1, DLY_W'(iv));
      pulse(7'h20, 1'b0);
      waitN(iv * SCALE - 1);
      check("R2 sweep before", 32'(irqOut), 0);
      nxt();
      check("R2 sweep at expiry", 32'(irqOut), 1);
      clr();
    end

    // receive packet timer restart
    cfg(0, 4, 0, 0, 0, 0);
    rx(100);                         // P0
    nxt();
    rx(100);                         // P2 -> P6
    waitN(3);
    check("R7 restarted timer quiet", 32'(irqOut), 0);
    nxt();
    check("R7 packet timer posts", 32'(causeOut), 32'h82);
    clr();

    // receive absolute bound, then cancelled packet timer
    cfg(0, 4, 7, 0, 0, 0);
    rx(100);                         // P0 abs to P7
    waitN(2);
    rx(100);                         // P3
    waitN(2);
    rx(100);                         // P6 pkt to P10
    check("R7 abs not yet", 32'(irqOut), 0);
    nxt();
    check("R7 abs timer posts", 32'(causeOut), 32'h82);
    clr();
    waitN(5);
    check("R4 packet timer cancelled", 32'(causeOut), 0);

    // receive delay sweep
    for (int d = 1; d <= 6; d++) begin
      wrReg(3'd2, DLY_W'(d));
      wrReg(3'd3, 8'd0);
      rx(100);
      if (d > 1) waitN(d - 1);
      check("R7 sweep before", 32'(irqOut), 0);
      nxt();
      check("R7 sweep at expiry", 32'(causeOut), 32'h82);
      clr();
    end

    // direct receive post and small packets
    cfg(0, 0, 0, 0, 0, 0);
    rx(100);
    check("R8 direct receive cause", 32'(causeOut), 32'h82);
    clr();
    wrReg(3'd6, 8'd64);
    rx(64);
    check("R9 small packet at limit", 32'(causeOut), 32'h86);
    clr();
    rx(65);
    check("R9 packet above limit", 32'(causeOut), 32'h82);
    clr();

    // fold of running receive timer into an immediate post
    cfg(0, 20, 0, 0, 0, 0);
    rx(100);                         // P0
    nxt();
    pulse(7'h08, 1'b1);              // P2
    check("R4 receive bit folded", 32'(causeOut), 32'h8A);
    clr();
    waitN(25);
    check("R4 folded timer gone", 32'(irqOut), 0);

    // transmit side
    cfg(0, 0, 0, 3, 0, 0);
    tx();
    waitN(2);
    check("R11 tx timer before", 32'(irqOut), 0);
    nxt();
    check("R11 tx timer posts", 32'(causeOut), 32'h81);
    clr();
    cfg(0, 0, 0, 0, 0, 0);
    tx();
    check("R11 tx direct post", 32'(causeOut), 32'h81);
    clr();
    for (int d = 1; d <= 5; d++) begin
      cfg(0, 0, 0, d + 4, d, 0);
      tx();
      if (d > 1) waitN(d - 1);
      check("R11 tx abs before", 32'(irqOut), 0);
      nxt();
      check("R11 tx abs posts", 32'(causeOut), 32'h81);
      clr();
      waitN(6);
      check("R4 tx packet timer cancelled", 32'(irqOut), 0);
    end

    // both directions at once
    cfg(0, 6, 0, 3, 0, 0);
    rxDone = 1'b1; rxLen = LEN_W'(100); txDone = 1'b1;
    nxt();
    rxDone = 1'b0; txDone = 1'b0;
    waitN(3);
    check("R11 tx fires first with rx folded", 32'(causeOut), 32'h83);
    clr();
    waitN(8);
    check("R4 rx timer cancelled by tx post", 32'(irqOut), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule